// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth Data Bit

The block is a serial port run from one 8-bit control and status register. Two mode bits choose one of four formats. The first is a synchronous shift register. The second is an asynchronous frame with 8 data bits. The last two are asynchronous frames with 9 data bits. In the synchronous format the data line `rxd` carries the data in both directions, and `txd` carries a shift clock at one sixth of the core clock. In the asynchronous formats `txd` is the serial output and `rxd_in` is the serial input. The receiver oversamples each bit 16 times.

The oversampling tick has two sources. In the variable-rate formats it comes from an external tick input, `baud_tick`. In the fixed 9-bit format it is derived from the core clock, and `div_sel` picks a bit time of 16 or 32 clocks. A ninth transmit bit and a ninth received bit sit in the register. A multiprocessor enable drops frames that do not carry an address marker. A framing-error flag is sticky and shares bit 7 with a mode bit. Software sees the flag or the mode bit depending on an access-select input. The transmit and receive interrupt flags are raised by hardware and can be set or cleared by register writes.

Top module: `sport_top`

## Requirements
- R1: After reset the register reads 0x00 (with either access select), `txd` is 1, `rxd_oe` is 0 and `rx_data` is 0x00.
- R2: Register bits from 7 down to 0 are: mode bit A, mode bit B, multiprocessor enable, receive enable, transmit ninth bit, received ninth bit, transmit flag, receive flag. The mode is {A,B}: 00 shift, 01 8-bit variable rate, 10 9-bit fixed rate, 11 9-bit variable rate. A write with `alt_sel`=0 puts bit 7 into mode bit A. A write with `alt_sel`=1 puts bit 7 into the framing-error flag. Reads select in the same way.
- R3: Writing `tx_data` in modes 01 and 11 sends one frame. The frame is a start bit of 0, the data bits LSB first, a ninth bit in mode 11, then a stop bit of 1. Each bit lasts 16 `baud_tick` pulses. The transmit flag is 0 during the last data bit and 1 during the stop bit.
- R4: In modes 10 and 11 the ninth transmitted bit equals register bit 3. In mode 10 the bit time is 16 clocks when `div_sel`=1 and 32 clocks when `div_sel`=0.
- R5: With receive enable at 1 in the asynchronous modes, a received frame with a valid stop bit sets the receive flag and loads `rx_data`. This holds for multiprocessor enable 0 in every asynchronous mode, and for enable 1 in mode 01. In mode 01 with multiprocessor enable 0, bit 2 takes the stop bit. This includes an invalid stop bit, which still sets the receive flag and leaves bit 2 at 0.
- R6: With receive enable at 0, frames on `rxd_in` leave the receive flag and `rx_data` unchanged.
- R7: In modes 10 and 11 the received ninth bit is stored in bit 2. With multiprocessor enable 1, a frame whose ninth bit is 0 sets no receive flag and leaves `rx_data` unchanged. A frame whose ninth bit is 1 is accepted.
- R8: In mode 01 with multiprocessor enable 1, a frame with a low stop bit does not set the receive flag and does not load `rx_data`. An invalid stop bit in any asynchronous mode sets the framing-error flag.
- R9: The framing-error flag stays at 1 through later valid frames. It is cleared only by a write with `alt_sel`=1 and bit 7 = 0, and that write leaves mode bit A unchanged.
- R10: In mode 00, writing `tx_data` drives the data on `rxd_out` with `rxd_oe`=1, LSB first. `txd` is a shift clock with a 6-clock period. Data is valid at each rising edge. After the 8th bit the transmit flag is set. When the port is idle in mode 00, `txd` is 1.
- R11: In mode 00, receive enable 1 together with receive flag 0 starts an 8-bit receive. The block samples `rxd_in` at each rising edge of the shift clock, LSB first. It then sets the receive flag, loads `rx_data` and leaves bit 2 unchanged.
- R12: A register write sets or clears the transmit and receive flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| alt_sel | input | 1 | Bit 7 access select: 1 framing-error flag, 0 mode bit A |
| reg_rdata | output | 8 | Control register read data |
| tx_wr | input | 1 | Transmit buffer write strobe, starts a transmission |
| tx_data | input | DATA_W | Transmit data |
| rx_data | output | DATA_W | Receive buffer |
| baud_tick | input | 1 | Oversampling tick for the variable-rate modes (16 per bit) |
| div_sel | input | 1 | Fixed-rate mode bit time: 1 gives 16 clocks, 0 gives 32 |
| rxd_in | input | 1 | Serial data input (asynchronous receive, mode 00 receive) |
| rxd_out | output | 1 | Mode 00 transmit data |
| rxd_oe | output | 1 | Drive enable for `rxd_out` |
| txd | output | 1 | Serial output, or the shift clock in mode 00 |

## Verification
The hardest cases are the ones where a frame is dropped while the framing-error flag still changes. One is a mode 01 frame with a low stop bit under multiprocessor enable. The other is a 9-bit frame with ninth bit 0 under the same enable. Reaching these needs the bench to build frames bit by bit, with a chosen stop level and ninth bit. It then has to show through the register and `rx_data` that nothing was taken, and then send a valid frame that the sticky flag must survive. The mode 00 receive runs only when receive enable is set and the receive flag is clear. For that case the bench follows the shift clock on `txd` and puts each new bit on `rxd_in` after each falling edge. Random bytes run through every format, with `baud_tick` pulses and the fixed-rate divide select.

// File: rtl/sport_pkg.sv
package sport_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_UART8  = 2'b01,
        MODE_UART9F = 2'b10,
        MODE_UART9V = 2'b11
    } sport_mode_e;

    typedef struct packed {
        logic fe;
        logic sm0;
        logic sm1;
        logic sm2;
        logic ren;
        logic tb8;
        logic rb8;
        logic ti;
        logic ri;
    } sport_ctrl_t;

endpackage

// File: rtl/sport_tickgen.sv
module sport_tickgen
    import sport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sport_mode_e mode,
    input  logic        baud_tick,
    input  logic        div_sel,
    output logic        os_tick
);

    logic tog_d, tog_q;

    always_comb begin
        tog_d = ~tog_q;
        case (mode)
            MODE_UART9F: os_tick = div_sel ? 1'b1 : tog_q;
            default:     os_tick = baud_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int M0_DIV  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sport_mode_e       mode,
    input  logic              tb8,
    input  logic              os_tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              txd_ser,
    output logic              m0_dout,
    output logic              m0_sclk,
    output logic              m0_active,
    output logic              busy,
    output logic              ti_set
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int PH_W    = $clog2(M0_DIV);

    typedef enum logic [1:0] {TX_IDLE, TX_ASYNC, TX_SHIFT} tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [PH_W-1:0]    ph;
        logic               ti;
    } tx_regs_t;

    tx_regs_t q, d;
    logic nine;
    logic [IDX_W-1:0] last;

    always_comb begin
        nine = mode[1];
        last = nine ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
        d    = q;
        d.ti = 1'b0;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.idx = '0;
                    d.cnt = '0;
                    d.ph  = '0;
                    if (mode == MODE_SHIFT) begin
                        d.st    = TX_SHIFT;
                        d.frame = {3'b000, data};
                    end else begin
                        d.st    = TX_ASYNC;
                        d.frame = {1'b1, (nine ? tb8 : 1'b1), data, 1'b0};
                    end
                end
            end
            TX_ASYNC: begin
                if (os_tick) begin
                    if (q.cnt == CNT_W'(OS_RATE - 1)) begin
                        d.cnt = '0;
                        if (q.idx == last) begin
                            d.st = TX_IDLE;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                            // flag rises together with the stop bit
                            d.ti  = ((q.idx + IDX_W'(1)) == last);
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            TX_SHIFT: begin
                if (q.ph == PH_W'(M0_DIV - 1)) begin
                    d.ph = '0;
                    if (q.idx == IDX_W'(DATA_W - 1)) begin
                        d.st = TX_IDLE;
                        d.ti = 1'b1;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end else begin
                    d.ph = q.ph + PH_W'(1);
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign txd_ser   = (q.st == TX_ASYNC) ? q.frame[q.idx] : 1'b1;
    assign m0_active = (q.st == TX_SHIFT);
    assign m0_dout   = q.frame[q.idx];
    assign m0_sclk   = (q.ph >= PH_W'(M0_DIV / 2));
    assign busy      = (q.st != TX_IDLE);
    assign ti_set    = q.ti;

endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int M0_DIV  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sport_mode_e       mode,
    input  logic              ren,
    input  logic              ri,
    input  logic              tx_busy,
    input  logic              os_tick,
    input  logic              rxd_in,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              stop,
    output logic              busy,
    output logic              m0_sclk,
    output logic              m0_active
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int PH_W    = $clog2(M0_DIV);
    localparam int MID     = OS_RATE / 2 - 1;

    typedef enum logic [1:0] {RX_IDLE, RX_ASYNC, RX_SHIFT} rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [1:0]         sync;
        logic               prev;
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [PH_W-1:0]    ph;
        logic [1:0]         votes;
        logic               done;
    } rx_regs_t;

    rx_regs_t q, d;
    logic line;
    logic vote;
    logic [1:0] vsum;
    logic [IDX_W-1:0] last;

    always_comb begin
        line   = q.sync[1];
        last   = mode[1] ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
        vsum   = q.votes + {1'b0, line};
        vote   = vsum[1];
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[0], rxd_in};
        d.prev = line;
        case (q.st)
            RX_IDLE: begin
                d.idx   = '0;
                d.cnt   = '0;
                d.ph    = '0;
                d.votes = '0;
                if (ren && mode != MODE_SHIFT && q.prev && !line) begin
                    d.st = RX_ASYNC;
                end else if (ren && mode == MODE_SHIFT && !ri && !tx_busy && !q.done) begin
                    d.st = RX_SHIFT;
                end
            end
            RX_ASYNC: begin
                if (os_tick) begin
                    if (q.cnt == CNT_W'(MID) || q.cnt == CNT_W'(MID + 1)) begin
                        d.votes = vsum;
                    end
                    if (q.cnt == CNT_W'(MID + 2)) begin
                        d.votes = '0;
                        if (q.idx == '0 && vote) begin
                            d.st = RX_IDLE;       // start bit not confirmed
                        end else begin
                            d.bits[q.idx] = vote;
                            if (q.idx == last) begin
                                d.st   = RX_IDLE;
                                d.done = 1'b1;
                            end
                        end
                    end
                    if (q.cnt == CNT_W'(OS_RATE - 1)) begin
                        d.cnt = '0;
                        d.idx = q.idx + IDX_W'(1);
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            RX_SHIFT: begin
                if (q.ph == PH_W'(M0_DIV - 1)) begin
                    d.ph = '0;
                    // synchronised value equals the pin two clocks earlier: the rising edge
                    d.bits[q.idx + IDX_W'(1)] = line;
                    if (q.idx == IDX_W'(DATA_W - 1)) begin
                        d.st   = RX_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end else begin
                    d.ph = q.ph + PH_W'(1);
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign data      = q.bits[DATA_W:1];
    assign ninth     = q.bits[DATA_W+1];
    assign stop      = mode[1] ? q.bits[DATA_W+2] : q.bits[DATA_W+1];
    assign busy      = (q.st != RX_IDLE);
    assign m0_active = (q.st == RX_SHIFT);
    assign m0_sclk   = (q.ph >= PH_W'(M0_DIV / 2));

endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int M0_DIV  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              alt_sel,
    output logic [7:0]        reg_rdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    input  logic              baud_tick,
    input  logic              div_sel,
    input  logic              rxd_in,
    output logic              rxd_out,
    output logic              rxd_oe,
    output logic              txd
);

    typedef struct packed {
        sport_ctrl_t       ctrl;
        logic [DATA_W-1:0] rxbuf;
    } top_regs_t;

    top_regs_t q, d;
    sport_mode_e mode;
    logic os_tick;
    logic tx_ser, tx_dout, tx_sclk, tx_m0, tx_busy, tx_ti;
    logic rx_done, rx_ninth, rx_stop, rx_busy, rx_sclk, rx_m0;
    logic [DATA_W-1:0] rx_word;
    logic accept, fe_set;

    assign mode = sport_mode_e'({q.ctrl.sm0, q.ctrl.sm1});

    sport_tickgen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .baud_tick (baud_tick),
        .div_sel   (div_sel),
        .os_tick   (os_tick)
    );

    sport_tx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .M0_DIV(M0_DIV)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .tb8       (q.ctrl.tb8),
        .os_tick   (os_tick),
        .start     (tx_wr),
        .data      (tx_data),
        .txd_ser   (tx_ser),
        .m0_dout   (tx_dout),
        .m0_sclk   (tx_sclk),
        .m0_active (tx_m0),
        .busy      (tx_busy),
        .ti_set    (tx_ti)
    );

    sport_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .M0_DIV(M0_DIV)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ren       (q.ctrl.ren),
        .ri        (q.ctrl.ri),
        .tx_busy   (tx_busy),
        .os_tick   (os_tick),
        .rxd_in    (rxd_in),
        .done      (rx_done),
        .data      (rx_word),
        .ninth     (rx_ninth),
        .stop      (rx_stop),
        .busy      (rx_busy),
        .m0_sclk   (rx_sclk),
        .m0_active (rx_m0)
    );

    always_comb begin
        d      = q;
        accept = 1'b0;
        fe_set = 1'b0;
        if (reg_wr) begin
            if (alt_sel) d.ctrl.fe  = reg_wdata[7];
            else         d.ctrl.sm0 = reg_wdata[7];
            d.ctrl.sm1 = reg_wdata[6];
            d.ctrl.sm2 = reg_wdata[5];
            d.ctrl.ren = reg_wdata[4];
            d.ctrl.tb8 = reg_wdata[3];
            d.ctrl.rb8 = reg_wdata[2];
            d.ctrl.ti  = reg_wdata[1];
            d.ctrl.ri  = reg_wdata[0];
        end
        // hardware events take priority over a write in the same cycle
        if (tx_ti) d.ctrl.ti = 1'b1;
        if (rx_done) begin
            case (mode)
                MODE_SHIFT: accept = 1'b1;
                MODE_UART8: begin
                    fe_set = !rx_stop;
                    accept = !q.ctrl.sm2 || rx_stop;
                    if (!q.ctrl.sm2) d.ctrl.rb8 = rx_stop;
                end
                default: begin
                    fe_set = !rx_stop;
                    accept = !q.ctrl.sm2 || rx_ninth;
                    if (accept) d.ctrl.rb8 = rx_ninth;
                end
            endcase
        end
        if (fe_set) d.ctrl.fe = 1'b1;
        if (accept) begin
            d.ctrl.ri = 1'b1;
            d.rxbuf   = rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata = {(alt_sel ? q.ctrl.fe : q.ctrl.sm0), q.ctrl.sm1, q.ctrl.sm2,
                        q.ctrl.ren, q.ctrl.tb8, q.ctrl.rb8, q.ctrl.ti, q.ctrl.ri};
    assign rx_data   = q.rxbuf;
    assign txd       = tx_m0 ? tx_sclk : (rx_m0 ? rx_sclk : tx_ser);
    assign rxd_out   = tx_m0 ? tx_dout : 1'b1;
    assign rxd_oe    = tx_m0;

endmodule

// File: rtl/sport_checker.sv
module sport_checker
    import sport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              alt_sel,
    input sport_ctrl_t       ctrl,
    input sport_mode_e       mode,
    input logic              rx_done,
    input logic              rx_ninth,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_busy,
    input logic              tx_busy,
    input logic              tx_ti,
    input logic              txd,
    input logic              rxd_oe
);

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.fe && !(reg_wr && alt_sel && !reg_wdata[7]) |=> ctrl.fe); // R9

    AST_ADDR_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && mode[1] && ctrl.sm2 && !rx_ninth |=> $stable(rx_data)); // R7

    AST_TI_FOLLOWS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ti |=> ctrl.ti); // R3

    AST_OE_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_oe |-> (mode == MODE_SHIFT)); // R10

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHIFT) && !tx_busy && !rx_busy |-> txd); // R10

    AST_RX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> $past(ctrl.ren)); // R6

    AST_SHIFT_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && (mode == MODE_SHIFT) |=> ctrl.ri); // R11

endmodule

bind sport_top sport_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .alt_sel   (alt_sel),
    .ctrl      (q.ctrl),
    .mode      (mode),
    .rx_done   (rx_done),
    .rx_ninth  (rx_ninth),
    .rx_data   (rx_data),
    .rx_busy   (rx_busy),
    .tx_busy   (tx_busy),
    .tx_ti     (tx_ti),
    .txd       (txd),
    .rxd_oe    (rxd_oe)
);

// File: tb/sport_top_tb_top.sv
`timescale 1ns/1ps
module sport_top_tb_top;

    logic clk = 1'b0;
    logic rst_n, reg_wr, alt_sel, tx_wr, baud_tick, div_sel, rxd_in;
    logic [7:0] reg_wdata, reg_rdata, tx_data, rx_data;
    logic rxd_out, rxd_oe, txd;
    int checks = 0, fails = 0, cyc = 0, bcnt = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        bcnt      <= (bcnt == 2) ? 0 : bcnt + 1;
        baud_tick <= (bcnt == 2);
    end

    sport_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .alt_sel(alt_sel), .reg_rdata(reg_rdata), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_data(rx_data), .baud_tick(baud_tick), .div_sel(div_sel), .rxd_in(rxd_in),
        .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [7:0] v, bit alt);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v; alt_sel = alt;
        @(negedge clk); reg_wr = 1'b0; alt_sel = 1'b0;
    endtask

    task automatic rd_reg(bit alt, output logic [7:0] v);
        alt_sel = alt; #1; v = reg_rdata; alt_sel = 1'b0; #1;
    endtask

    task automatic wait_txd(logic lvl);
        int g = 0;
        while (txd !== lvl && g < 5000) begin @(negedge clk); g++; end
    endtask

    function automatic bit exp_accept(logic [1:0] m, bit sm2, bit n9, bit sb);
        if (m == 2'b00) return 1'b1;
        if (m == 2'b01) return !sm2 || sb;
        return !sm2 || n9;
    endfunction

    function automatic bit exp_rb8(logic [1:0] m, bit sm2, bit n9, bit sb, bit old);
        if (m == 2'b00) return old;
        if (m == 2'b01) return sm2 ? old : sb;
        return exp_accept(m, sm2, n9, sb) ? n9 : old;
    endfunction

    task automatic send_async(logic [7:0] b, bit nine, bit n9, bit sb, int bc);
        @(negedge clk); rxd_in = 1'b0; wclk(bc);
        for (int i = 0; i < 8; i++) begin rxd_in = b[i]; wclk(bc); end
        if (nine) begin rxd_in = n9; wclk(bc); end
        rxd_in = sb; wclk(bc);
        rxd_in = 1'b1; wclk(2 * bc);
    endtask

    task automatic rx_case(string req, logic [7:0] cfg, logic [7:0] b, bit n9, bit sb, int bc);
        logic [7:0] old, r;
        bit acc;
        wr_reg(cfg, 1'b0);
        old = rx_data;
        send_async(b, cfg[6] ? cfg[7] : 1'b0, n9, sb, bc);
        acc = cfg[4] && exp_accept(cfg[7:6], cfg[5], n9, sb);
        rd_reg(1'b0, r);
        chk(r[0] == acc, {req, " receive flag"}, r[0], acc);
        chk(rx_data == (acc ? b : old), {req, " rx_data"}, rx_data, acc ? b : old);
        chk(r[2] == (cfg[4] ? exp_rb8(cfg[7:6], cfg[5], n9, sb, cfg[2]) : cfg[2]),
            {req, " ninth bit"}, r[2], cfg[4] ? exp_rb8(cfg[7:6], cfg[5], n9, sb, cfg[2]) : cfg[2]);
    endtask

    task automatic tx_case(string req, logic [7:0] cfg, logic [7:0] b, int bc);
        logic [7:0] got;
        bit nine, n9, sb, ti_pre, ti_stop;
        nine = cfg[7];
        wr_reg(cfg, 1'b0);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
        wait_txd(1'b0);
        wclk(bc / 2);
        for (int i = 0; i < 8; i++) begin
            wclk(bc); got[i] = txd;
            if (i == 7) ti_pre = reg_rdata[1];
        end
        n9 = 1'b0;
        if (nine) begin wclk(bc); n9 = txd; ti_pre = reg_rdata[1]; end
        wclk(bc); sb = txd; ti_stop = reg_rdata[1];
        wclk(bc);
        chk(got == b, {req, " tx data"}, got, b);
        if (nine) chk(n9 == cfg[3], {req, " tx ninth bit"}, n9, cfg[3]);
        chk(sb == 1'b1, {req, " stop bit"}, sb, 1);
        chk(ti_pre == 1'b0, {req, " flag before stop"}, ti_pre, 0);
        chk(ti_stop == 1'b1, {req, " flag in stop"}, ti_stop, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r, b, got;
        int t0, t1;
        bit oe_ok;
        void'($urandom(32'h5EED_1234));
        rst_n = 0; reg_wr = 0; reg_wdata = 0; alt_sel = 0; tx_wr = 0; tx_data = 0;
        div_sel = 0; rxd_in = 1;
        wclk(5); rst_n = 1; wclk(3);

        rd_reg(1'b0, r); chk(r == 8'h00, "R1 register", r, 0);
        rd_reg(1'b1, r); chk(r == 8'h00, "R1 register alt", r, 0);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(rxd_oe == 1'b0, "R1 rxd_oe", rxd_oe, 0);
        chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);

        wr_reg(8'hC0, 1'b0);
        rd_reg(1'b0, r); chk(r == 8'hC0, "R2 mode bits", r, 8'hC0);
        rd_reg(1'b1, r); chk(r == 8'h40, "R2 alt view", r, 8'h40);

        wr_reg(8'h03, 1'b0);
        rd_reg(1'b0, r); chk(r == 8'h03, "R12 set flags", r, 3);
        wr_reg(8'h00, 1'b0);
        rd_reg(1'b0, r); chk(r == 8'h00, "R12 clear flags", r, 0);

        for (int i = 0; i < 4; i++) rx_case("R5 mode1", 8'h50, 8'($urandom), 1'b0, 1'b1, 48);
        rx_case("R5 mode1 bad stop", 8'h50, 8'h3C, 1'b0, 1'b0, 48);
        rx_case("R6 disabled", 8'h40, 8'hA5, 1'b0, 1'b1, 48);

        for (int i = 0; i < 3; i++) tx_case("R3 mode1", 8'h40, 8'($urandom), 48);

        wr_reg(8'h70, 1'b1);   // clear framing flag, mode 01
        rx_case("R8 bad stop filtered", 8'h70, 8'h96, 1'b0, 1'b0, 48);
        rd_reg(1'b1, r); chk(r[7] == 1'b1, "R8 framing flag", r[7], 1);
        rx_case("R9 valid frame", 8'h70, 8'h5A, 1'b0, 1'b1, 48);
        rd_reg(1'b1, r); chk(r[7] == 1'b1, "R9 flag survives", r[7], 1);
        wr_reg(8'h70, 1'b1);
        rd_reg(1'b1, r); chk(r[7] == 1'b0, "R9 flag cleared", r[7], 0);
        rd_reg(1'b0, r); chk(r == 8'h70, "R9 mode kept", r, 8'h70);

        for (int i = 0; i < 4; i++)
            rx_case("R7 mode3", 8'hD0, 8'($urandom), 1'($urandom), 1'b1, 48);
        rx_case("R7 address filter drop", 8'hF0, 8'h11, 1'b0, 1'b1, 48);
        rx_case("R7 address accept", 8'hF0, 8'h22, 1'b1, 1'b1, 48);
        div_sel = 1'b1;
        rx_case("R7 mode2 fast", 8'h90, 8'($urandom), 1'b1, 1'b1, 16);

        tx_case("R4 mode3 ninth1", 8'hC8, 8'($urandom), 48);
        tx_case("R4 mode3 ninth0", 8'hC0, 8'($urandom), 48);
        tx_case("R4 mode2 div16", 8'h88, 8'($urandom), 16);
        div_sel = 1'b0;
        tx_case("R4 mode2 div32", 8'h80, 8'($urandom), 32);

        wr_reg(8'h00, 1'b0);
        chk(txd == 1'b1, "R10 idle clock", txd, 1);
        b = 8'($urandom);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
        oe_ok = 1'b1; t0 = 0; t1 = 0;
        for (int i = 0; i < 8; i++) begin
            wait_txd(1'b0); wait_txd(1'b1);
            got[i] = rxd_out;
            if (!rxd_oe) oe_ok = 1'b0;
            if (i == 0) t0 = cyc;
            if (i == 1) t1 = cyc;
        end
        wclk(8);
        chk(got == b, "R10 shift data", got, b);
        chk(oe_ok, "R10 drive enable", oe_ok, 1);
        chk((t1 - t0) == 6, "R10 clock period", t1 - t0, 6);
        rd_reg(1'b0, r); chk(r[1] == 1'b1, "R10 transmit flag", r[1], 1);

        b = 8'($urandom);
        rxd_in = b[0];
        wr_reg(8'h14, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_txd(1'b0);
            if (i > 0) rxd_in = b[i];
            wait_txd(1'b1);
        end
        wclk(10);
        rxd_in = 1'b1;
        rd_reg(1'b0, r);
        chk(r[0] == 1'b1, "R11 receive flag", r[0], 1);
        chk(rx_data == b, "R11 rx_data", rx_data, b);
        chk(r[2] == 1'b1, "R11 ninth bit kept", r[2], 1);

        summary();
        $finish;
    end

endmodule